// File: doc/BRIEF.md
# Oscillator Calibration Start-Point Calculator

This block turns a requested oscillator frequency, given as an integer number of MHz, into the three seed values that a frequency calibration starts from: a core index, a band capacitor code and an amplitude code. Good seeds shorten the calibration. Poor seeds still converge, but they take longer.

A request is a single-cycle `start_i` with the frequency and a mode bit. In interpolated mode the block finds the core whose frequency window holds the request. It then interpolates both codes linearly between that core's endpoint values and rounds the result half-up. The arithmetic runs through two restoring dividers that resolve one quotient bit per clock. In default mode, and in the exclusion band around 12 GHz, fixed values are returned at once. A request outside the supported range returns the default values with an error flag. The result is signalled by a one-cycle `done_o`, and the outputs hold until the next result.

Top module: `vco_start_calc`

## Requirements
- R1: After reset, `done_o` and `range_err_o` are 0, and the outputs hold the default values: core 7, capacitor code 183, amplitude code 300.
- R2: A frequency below 7500 or above 15000 produces `done_o` with `range_err_o`=1 and the default values (core 7, capacitor 183, amplitude 300), in either mode.
- R3: A frequency from 11900 to 12100 inclusive produces core 4, capacitor code 1 and amplitude code 300, with `range_err_o`=0, in either mode.
- R4: With `assist_i`=0, an in-range frequency outside the exclusion band produces core 7, capacitor 183 and amplitude 300, with `range_err_o`=0.
- R5: With `assist_i`=1, in range and outside the band, the core index is k (1..7). Here k is the lowest core whose upper edge is at least the frequency. The upper edges are 8600, 9800, 10800, 12000, 12900, 13900 and 15000, and core 1 starts at 7500. A frequency exactly on a shared edge therefore takes the lower core.
- R6: In interpolated mode the capacitor code is floor((Ca·S − (Ca−Cb)·d + S/2)/S), with d = f − fmin and S the core span. The endpoint pairs (Ca at fmin, Cb at fmax) are: core1 164/12, core2 165/16, core3 158/19, core4 140/0, core5 183/36, core6 155/6, core7 175/19.
- R7: In interpolated mode the amplitude code is floor((Aa·S + (Ab−Aa)·d + S/2)/S). The endpoint pairs (Aa, Ab) are: core1 299/240, core2 356/247, core3 324/224, core4 383/244, core5 205/146, core6 242/163, core7 323/244.
- R8: `done_o` is high for exactly one cycle. Counting from the clock edge that accepts `start_i`, it is visible 1 cycle later for the fixed-value and error cases, and 21 cycles later for an interpolated result.
- R9: A `start_i` that arrives while a computation is in progress is ignored, and no second result follows. The outputs change only in a cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse; ignored while busy |
| freq_i | input | 14 | Requested frequency in MHz |
| assist_i | input | 1 | 1 = interpolated seeds, 0 = fixed defaults |
| done_o | output | 1 | One-cycle result strobe |
| core_o | output | 3 | Core index 1..7 |
| cap_o | output | 8 | Band capacitor code |
| amp_o | output | 9 | Amplitude code |
| range_err_o | output | 1 | Requested frequency out of range |

## Verification
The assertions check, on every result, the following:
- the forced values for the error, exclusion-band and default-mode cases;
- that an interpolated core's window contains the request;
- that both codes lie between that core's endpoint values;
- the single-cycle strobe, the latency bound, and that outputs hold between results.

Whether an interpolated code is rounded to the exact value, and how ties at exactly one half are resolved, can only be shown by the bench. The bench compares every result against its own computation, over random and edge frequencies. The bench scenarios also show the exact latency per path and that a mid-computation request is dropped.

// File: rtl/vco_start_pkg.sv
package vco_start_pkg;
  localparam int FREQ_W  = 14;
  localparam int CORE_W  = 3;
  localparam int CAP_W   = 8;
  localparam int AMP_W   = 9;
  localparam int SPAN_W  = 11;
  localparam int NUM_W   = 19;
  localparam int N_CORES = 7;
  localparam int CNT_W   = $clog2(NUM_W);

  localparam logic [FREQ_W-1:0] F_LO    = FREQ_W'(7500);
  localparam logic [FREQ_W-1:0] F_HI    = FREQ_W'(15000);
  localparam logic [FREQ_W-1:0] BAND_LO = FREQ_W'(11900);
  localparam logic [FREQ_W-1:0] BAND_HI = FREQ_W'(12100);

  localparam logic [CORE_W-1:0] DEF_CORE  = CORE_W'(7);
  localparam logic [CAP_W-1:0]  DEF_CAP   = CAP_W'(183);
  localparam logic [AMP_W-1:0]  DEF_AMP   = AMP_W'(300);
  localparam logic [CORE_W-1:0] BAND_CORE = CORE_W'(4);
  localparam logic [CAP_W-1:0]  BAND_CAP  = CAP_W'(1);
  localparam logic [AMP_W-1:0]  BAND_AMP  = AMP_W'(300);

  typedef struct packed {
    logic [FREQ_W-1:0] f_lo;
    logic [SPAN_W-1:0] span;
    logic [CAP_W-1:0]  cap_a;
    logic [CAP_W-1:0]  cap_b;
    logic [AMP_W-1:0]  amp_a;
    logic [AMP_W-1:0]  amp_b;
  } core_ent_t;

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_FIN} calc_st_e;

  function automatic logic [FREQ_W-1:0] core_top(input logic [CORE_W-1:0] idx);
    case (idx)
      3'd1:    return FREQ_W'(8600);
      3'd2:    return FREQ_W'(9800);
      3'd3:    return FREQ_W'(10800);
      3'd4:    return FREQ_W'(12000);
      3'd5:    return FREQ_W'(12900);
      3'd6:    return FREQ_W'(13900);
      default: return FREQ_W'(15000);
    endcase
  endfunction

  function automatic core_ent_t mk_ent(input int fl, input int fh, input int ca,
                                       input int cb, input int aa, input int ab);
    core_ent_t e;
    e.f_lo  = FREQ_W'(fl);
    e.span  = SPAN_W'(fh - fl);
    e.cap_a = CAP_W'(ca);
    e.cap_b = CAP_W'(cb);
    e.amp_a = AMP_W'(aa);
    e.amp_b = AMP_W'(ab);
    return e;
  endfunction

  function automatic core_ent_t core_ent(input logic [CORE_W-1:0] idx);
    case (idx)
      3'd1:    return mk_ent(7500,  8600,  164, 12, 299, 240);
      3'd2:    return mk_ent(8600,  9800,  165, 16, 356, 247);
      3'd3:    return mk_ent(9800,  10800, 158, 19, 324, 224);
      3'd4:    return mk_ent(10800, 12000, 140, 0,  383, 244);
      3'd5:    return mk_ent(12000, 12900, 183, 36, 205, 146);
      3'd6:    return mk_ent(12900, 13900, 155, 6,  242, 163);
      default: return mk_ent(13900, 15000, 175, 19, 323, 244);
    endcase
  endfunction
endpackage

// File: rtl/vco_core_sel.sv
module vco_core_sel
  import vco_start_pkg::*;
(
  input  logic [FREQ_W-1:0] freq_i,
  output logic [CORE_W-1:0] core_o,
  output core_ent_t         ent_o
);
  logic [N_CORES-2:0] above;

  for (genvar g = 0; g < N_CORES - 1; g++) begin : g_cmp
    assign above[g] = freq_i > core_top(CORE_W'(g + 1));
  end

  // edge value stays in the lower core
  always_comb begin
    core_o = CORE_W'(1);
    for (int i = 0; i < N_CORES - 1; i++) core_o = core_o + CORE_W'(above[i]);
  end

  assign ent_o = core_ent(core_o);
endmodule

// File: rtl/vco_rdiv.sv
module vco_rdiv #(
  parameter int NUM_W = 19,
  parameter int DEN_W = 11,
  parameter int Q_W   = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [NUM_W-1:0] numer_i,
  input  logic [DEN_W-1:0] denom_i,
  output logic [Q_W-1:0]   quot_o
);
  logic [NUM_W-1:0] q_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [DEN_W:0]   trial;
  logic             fits;

  assign trial = {rem_q, q_q[NUM_W-1]};
  assign fits  = trial >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= '0;
      rem_q <= '0;
      den_q <= '0;
    end else if (load_i) begin
      q_q   <= numer_i;
      rem_q <= '0;
      den_q <= denom_i;
    end else if (step_i) begin
      rem_q <= fits ? DEN_W'(trial - {1'b0, den_q}) : DEN_W'(trial);
      q_q   <= {q_q[NUM_W-2:0], fits};
    end
  end

  assign quot_o = q_q[Q_W-1:0];
endmodule

// File: rtl/vco_start_calc.sv
module vco_start_calc
  import vco_start_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic              assist_i,
  output logic              done_o,
  output logic [CORE_W-1:0] core_o,
  output logic [CAP_W-1:0]  cap_o,
  output logic [AMP_W-1:0]  amp_o,
  output logic              range_err_o
);
  calc_st_e          state;
  logic [CNT_W-1:0]  cnt;
  logic [CORE_W-1:0] core_q;
  logic              busy, accept, out_rng, in_band, go_div;

  logic [CORE_W-1:0] sel_core;
  core_ent_t         sel_ent;
  logic [NUM_W-1:0]  cap_num, amp_num;
  logic [CAP_W-1:0]  cap_quot;
  logic [AMP_W-1:0]  amp_quot;

  vco_core_sel u_sel (
    .freq_i (freq_i),
    .core_o (sel_core),
    .ent_o  (sel_ent)
  );

  assign busy    = state != S_IDLE;
  assign accept  = start_i && !busy;
  assign out_rng = (freq_i < F_LO) || (freq_i > F_HI);
  assign in_band = (freq_i >= BAND_LO) && (freq_i <= BAND_HI);
  assign go_div  = accept && !out_rng && !in_band && assist_i;

  // scaled numerators with half-span bias for half-up rounding
  always_comb begin
    int span_v, df_v, cn, an;
    span_v  = int'(sel_ent.span);
    df_v    = int'(freq_i) - int'(sel_ent.f_lo);
    cn      = int'(sel_ent.cap_a) * span_v
            - (int'(sel_ent.cap_a) - int'(sel_ent.cap_b)) * df_v + span_v / 2;
    an      = int'(sel_ent.amp_a) * span_v
            + (int'(sel_ent.amp_b) - int'(sel_ent.amp_a)) * df_v + span_v / 2;
    cap_num = NUM_W'(cn);
    amp_num = NUM_W'(an);
  end

  vco_rdiv #(.NUM_W(NUM_W), .DEN_W(SPAN_W), .Q_W(CAP_W)) u_div_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (go_div),
    .step_i  (state == S_DIV),
    .numer_i (cap_num),
    .denom_i (sel_ent.span),
    .quot_o  (cap_quot)
  );

  vco_rdiv #(.NUM_W(NUM_W), .DEN_W(SPAN_W), .Q_W(AMP_W)) u_div_amp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (go_div),
    .step_i  (state == S_DIV),
    .numer_i (amp_num),
    .denom_i (sel_ent.span),
    .quot_o  (amp_quot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= S_IDLE;
      cnt         <= '0;
      core_q      <= DEF_CORE;
      done_o      <= 1'b0;
      core_o      <= DEF_CORE;
      cap_o       <= DEF_CAP;
      amp_o       <= DEF_AMP;
      range_err_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            if (out_rng) begin
              done_o <= 1'b1; range_err_o <= 1'b1;
              core_o <= DEF_CORE; cap_o <= DEF_CAP; amp_o <= DEF_AMP;
            end else if (in_band) begin
              done_o <= 1'b1; range_err_o <= 1'b0;
              core_o <= BAND_CORE; cap_o <= BAND_CAP; amp_o <= BAND_AMP;
            end else if (!assist_i) begin
              done_o <= 1'b1; range_err_o <= 1'b0;
              core_o <= DEF_CORE; cap_o <= DEF_CAP; amp_o <= DEF_AMP;
            end else begin
              state  <= S_DIV;
              cnt    <= '0;
              core_q <= sel_core;
            end
          end
        end
        S_DIV: begin
          cnt <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(NUM_W - 1)) state <= S_FIN;
        end
        S_FIN: begin
          state       <= S_IDLE;
          done_o      <= 1'b1;
          range_err_o <= 1'b0;
          core_o      <= core_q;
          cap_o       <= cap_quot;
          amp_o       <= amp_quot;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vco_start_calc_chk.sv
module vco_start_calc_chk
  import vco_start_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [FREQ_W-1:0] freq_i,
  input logic              assist_i,
  input logic              busy_i,
  input logic              done_o,
  input logic [CORE_W-1:0] core_o,
  input logic [CAP_W-1:0]  cap_o,
  input logic [AMP_W-1:0]  amp_o,
  input logic              range_err_o
);
  localparam int LAT_MAX = NUM_W + 2;

  logic [FREQ_W-1:0] lat_f;
  logic              lat_m;
  logic [5:0]        acc_cnt;
  logic              lat_oor, lat_band, interp_case;
  logic [FREQ_W-1:0] lo_bound;
  core_ent_t         ent;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_f   <= '0;
      lat_m   <= 1'b0;
      acc_cnt <= '0;
    end else if (start_i && !busy_i) begin
      lat_f   <= freq_i;
      lat_m   <= assist_i;
      acc_cnt <= 6'd1;
    end else if (acc_cnt < 6'(LAT_MAX + 1)) begin
      acc_cnt <= acc_cnt + 6'd1;
    end
  end

  assign lat_oor     = (lat_f < F_LO) || (lat_f > F_HI);
  assign lat_band    = (lat_f >= BAND_LO) && (lat_f <= BAND_HI);
  assign interp_case = !lat_oor && !lat_band && lat_m;
  assign lo_bound    = (core_o == CORE_W'(1)) ? F_LO - FREQ_W'(1) : core_top(core_o - CORE_W'(1));
  assign ent         = core_ent(core_o);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_LATENCY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (acc_cnt != 6'd0) && (acc_cnt <= 6'(LAT_MAX))); // R8
  AST_RANGE_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && lat_oor |-> range_err_o && core_o == DEF_CORE && cap_o == DEF_CAP && amp_o == DEF_AMP); // R2
  AST_BAND_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !lat_oor && lat_band |-> !range_err_o && core_o == BAND_CORE && cap_o == BAND_CAP && amp_o == BAND_AMP); // R3
  AST_DEFAULT_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !lat_oor && !lat_band && !lat_m |-> !range_err_o && core_o == DEF_CORE && cap_o == DEF_CAP && amp_o == DEF_AMP); // R4
  AST_CORE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && interp_case |-> core_o != '0 && lat_f > lo_bound && lat_f <= core_top(core_o)); // R5
  AST_CAP_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && interp_case |-> cap_o <= ent.cap_a && cap_o >= ent.cap_b); // R6
  AST_AMP_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && interp_case |-> amp_o <= ent.amp_a && amp_o >= ent.amp_b); // R7
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(core_o) && $stable(cap_o) && $stable(amp_o) && $stable(range_err_o)); // R9
endmodule

bind vco_start_calc vco_start_calc_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .freq_i      (freq_i),
  .assist_i    (assist_i),
  .busy_i      (busy),
  .done_o      (done_o),
  .core_o      (core_o),
  .cap_o       (cap_o),
  .amp_o       (amp_o),
  .range_err_o (range_err_o)
);

// File: tb/vco_start_calc_tb.sv
`timescale 1ns/1ps
module vco_start_calc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [13:0] freq = '0;
  logic        assist = 1'b0;
  logic        done;
  logic [2:0]  core;
  logic [7:0]  cap;
  logic [8:0]  amp;
  logic        rerr;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  vco_start_calc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .freq_i(freq), .assist_i(assist),
    .done_o(done), .core_o(core), .cap_o(cap), .amp_o(amp), .range_err_o(rerr)
  );

  int edge_tbl [8] = '{7500, 8600, 9800, 10800, 12000, 12900, 13900, 15000};
  int ca_tbl [7] = '{164, 165, 158, 140, 183, 155, 175};
  int cb_tbl [7] = '{12, 16, 19, 0, 36, 6, 19};
  int aa_tbl [7] = '{299, 356, 324, 383, 205, 242, 323};
  int ab_tbl [7] = '{240, 247, 224, 244, 146, 163, 244};

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // kind: 0 range error, 1 band, 2 default mode, 3 interpolated
  task automatic expect_of(input int f, input bit m, output int kind, output int ec,
                           output int ecap, output int eamp);
    int sp, d;
    if (f < 7500 || f > 15000) begin kind = 0; ec = 7; ecap = 183; eamp = 300; end
    else if (f >= 11900 && f <= 12100) begin kind = 1; ec = 4; ecap = 1; eamp = 300; end
    else if (!m) begin kind = 2; ec = 7; ecap = 183; eamp = 300; end
    else begin
      kind = 3;
      ec = 7;
      for (int k = 7; k >= 1; k--) if (f <= edge_tbl[k]) ec = k;
      sp   = edge_tbl[ec] - edge_tbl[ec-1];
      d    = f - edge_tbl[ec-1];
      ecap = (ca_tbl[ec-1] * sp - (ca_tbl[ec-1] - cb_tbl[ec-1]) * d + sp / 2) / sp;
      eamp = (aa_tbl[ec-1] * sp + (ab_tbl[ec-1] - aa_tbl[ec-1]) * d + sp / 2) / sp;
    end
  endtask

  task automatic check_result(input int f, input bit m, input int lat);
    int kind, ec, ecap, eamp;
    string t;
    expect_of(f, m, kind, ec, ecap, eamp);
    chk("R8 latency", lat, (kind == 3) ? 21 : 1);
    t = (kind == 0) ? "R2" : (kind == 1) ? "R3" : (kind == 2) ? "R4" : "R5";
    chk({t, " core"}, int'(core), ec);
    chk({t, " error flag"}, int'(rerr), (kind == 0) ? 1 : 0);
    t = (kind == 3) ? "R6" : t;
    chk({t, " cap"}, int'(cap), ecap);
    t = (kind == 3) ? "R7" : t;
    chk({t, " amp"}, int'(amp), eamp);
  endtask

  task automatic run(input int f, input bit m);
    int lat = 0;
    @(negedge clk);
    freq = 14'(f); assist = m; start = 1'b1;
    do begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end while (!done && lat < 100);
    check_result(f, m, lat);
    @(negedge clk);
    chk("R8 pulse width", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int seen, lat, c0, k0, a0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", int'(done), 0);
    chk("R1 core", int'(core), 7);
    chk("R1 cap", int'(cap), 183);
    chk("R1 amp", int'(amp), 300);
    chk("R1 error flag", int'(rerr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed edges
    foreach (edge_tbl[i]) begin
      run(edge_tbl[i], 1'b1);
      run(edge_tbl[i] + 1, 1'b1);
      run(edge_tbl[i] - 1, 1'b1);
    end
    run(11899, 1'b1); run(11900, 1'b1); run(12100, 1'b1); run(12101, 1'b1);
    run(11950, 1'b0); run(12000, 1'b0);
    run(7499, 1'b1); run(15001, 1'b0); run(0, 1'b1); run(16383, 1'b1);
    run(9000, 1'b0); run(14500, 1'b0);

    // R9: a request while busy is dropped
    @(negedge clk);
    freq = 14'd8000; assist = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    freq = 14'd14000; assist = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 5;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check_result(8000, 1'b1, lat);
    k0 = int'(core); c0 = int'(cap); a0 = int'(amp);
    seen = 0;
    repeat (30) begin @(negedge clk); if (done) seen++; end
    chk("R9 no second result", seen, 0);
    chk("R9 core held", int'(core), k0);
    chk("R9 cap held", int'(cap), c0);
    chk("R9 amp held", int'(amp), a0);

    // random sweep
    for (int n = 0; n < 400; n++) begin
      int f = 7000 + int'($urandom_range(0, 8500));
      run(f, 1'(($urandom_range(0, 3) != 0)));
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule